// File: doc/BRIEF.md
# Up-Counting Alarm Timer

This block is a memory-mapped 32-bit timer that counts upward at a selectable rate and raises an interrupt when its count reaches a programmed alarm value. Software talks to it through a plain register port made of an address, a write strobe, write data and combinational read data. Writing the start-value register places that value in the counter at once. The counter then advances on every clock, every 16th clock or every 256th clock while the run bit is set.

When the counter steps onto the alarm value, an event is recorded. In pulse mode the interrupt line is high for exactly that one cycle. In held mode the line stays high until software acknowledges it through the acknowledge register. A recorded event also shows in a sticky status bit of the control word in both modes. When the counter passes all ones it wraps to zero, or, if the reload flag is set, it restarts from the start value.

Top module: `alarm_timer`

## Requirements
- R1: After reset, every register reads zero (start value 0x20, count 0x24, control 0x28, acknowledge 0x2C, alarm 0x30) and the interrupt output is low.
- R2: Start value (0x20) and alarm (0x30) read back as written. The control word at 0x28 reads bit 7 run, bit 6 reload, bits 3:2 rate, bit 0 mode and bit 8 status, with all other bits zero. A write to the count address 0x24 has no effect.
- R3: A write to the start-value register sets the count to the written value on the same clock edge, and this takes priority over a counting step.
- R4: While control bit 7 is 0, the count does not change.
- R5: Rate field bits 3:2 select the step rate: 0 steps on every cycle, 1 on every 16th cycle and 2 or 3 on every 256th cycle, counted from the edge that set bit 7.
- R6: With control bit 6 clear, a step from all ones gives zero.
- R7: With control bit 6 set, a step from all ones loads the start-value register into the count.
- R8: A step that brings the count to the alarm value sets status bit 8 of the control word in the same cycle that the count shows the alarm value.
- R9: With control bit 0 = 0 (pulse mode), the interrupt output is high only in the single cycle after the matching step.
- R10: With control bit 0 = 1 (held mode), the interrupt output follows the status bit: it stays high until a write to 0x2C with bit 0 = 1 clears it.
- R11: A count that equals the alarm without a counting step never raises an event. This covers the counter standing still with run cleared, a rate prescaler between steps, and a start-value write that lands on the alarm.
- R12: A write to 0x2C with bit 0 = 0 leaves the status bit and the held interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt, pulse or held according to control bit 0 |

## Verification
The bench checks the exact cycle in which each rate setting delivers its first step. A prescaler off by one would show the old count one sample too late or too early. It drives the count across all ones with and without the reload flag, so a design that ignored the flag, or reloaded on every step, returns the wrong value right after the wrap. It puts the count on the alarm without a step: by a start-value write with the counter stopped, and by running the slowest rate while the count sits on the alarm. A design that compared levels instead of steps would raise a spurious event there. It also writes the acknowledge register with bit 0 clear, which a design that ignored the data bit would wrongly treat as a clear.

// File: rtl/alarm_timer_pkg.sv
package alarm_timer_pkg;

    localparam int unsigned PRE_W = 8;

    localparam logic [7:0] OFS_START = 8'h20;
    localparam logic [7:0] OFS_COUNT = 8'h24;
    localparam logic [7:0] OFS_CTRL  = 8'h28;
    localparam logic [7:0] OFS_ACK   = 8'h2C;
    localparam logic [7:0] OFS_ALARM = 8'h30;

    typedef enum logic [1:0] {
        RATE_1     = 2'd0,
        RATE_16    = 2'd1,
        RATE_256   = 2'd2,
        RATE_256_B = 2'd3
    } rate_e;

    typedef enum logic {
        MODE_PULSE = 1'b0,
        MODE_HELD  = 1'b1
    } irq_mode_e;

    typedef struct packed {
        logic      run;
        logic      reload;
        rate_e     rate;
        irq_mode_e mode;
    } ctrl_t;

    // Low bits of the prescaler that must all be one for a step.
    function automatic logic [PRE_W-1:0] rate_mask(rate_e sel);
        logic [PRE_W-1:0] m;
        case (sel)
            RATE_1:  m = '0;
            RATE_16: m = PRE_W'(8'h0F);
            default: m = PRE_W'(8'hFF);
        endcase
        return m;
    endfunction

    function automatic logic [31:0] ctrl_word(ctrl_t c, logic status);
        logic [31:0] w;
        w    = '0;
        w[8] = status;
        w[7] = c.run;
        w[6] = c.reload;
        w[3:2] = c.rate;
        w[0] = c.mode;
        return w;
    endfunction

endpackage

// File: rtl/at_prescaler.sv
module at_prescaler
    import alarm_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  rate_e rate,
    output logic  tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = rate_mask(rate);
        tick = run && ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    AST_RATE_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && rate != RATE_1) |=> (!tick || rate == RATE_1)); // R5

endmodule

// File: rtl/at_counter.sv
module at_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start_we,
    input  logic [CNT_W-1:0] start_din,
    input  logic [CNT_W-1:0] start_q,
    input  logic             reload,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             step
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    always_comb begin
        step = tick && !start_we;
        if (cnt == ALL_ONES) begin
            cnt_nxt = reload ? start_q : '0;
        end else begin
            cnt_nxt = cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start_we) begin
            cnt <= start_din;
        end else if (tick) begin
            cnt <= cnt_nxt;
        end
    end

    AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
        start_we |=> (cnt == $past(start_din))); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!tick && !start_we) |=> $stable(cnt)); // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (step && cnt == ALL_ONES && !reload) |=> (cnt == '0)); // R6
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (step && cnt == ALL_ONES && reload) |=> (cnt == $past(start_q))); // R7

endmodule

// File: rtl/at_irq_unit.sv
module at_irq_unit
    import alarm_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] alarm,
    input  irq_mode_e        mode,
    input  logic             ack,
    output logic             hit,
    output logic             status,
    output logic             irq
);

    logic match;

    always_comb begin
        match = step && (cnt_nxt == alarm);
        irq   = (mode == MODE_HELD) ? status : hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit    <= 1'b0;
            status <= 1'b0;
        end else begin
            hit <= match;
            if (match) begin
                status <= 1'b1;
            end else if (ack) begin
                status <= 1'b0;
            end
        end
    end

    AST_HIT_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        hit |-> status); // R8
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status && !ack) |=> status); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && !match) |=> !status); // R10

endmodule

// File: rtl/alarm_timer.sv
module alarm_timer
    import alarm_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] alarm_q;
    ctrl_t            ctrl_q;

    logic             sel_start, sel_count, sel_ctrl, sel_ack, sel_alarm;
    logic             start_we, alarm_we, ctrl_we, ack_w;
    logic             tick, step, hit, status;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_comb begin
        sel_start = (bus_addr == ADDR_W'(OFS_START));
        sel_count = (bus_addr == ADDR_W'(OFS_COUNT));
        sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
        sel_ack   = (bus_addr == ADDR_W'(OFS_ACK));
        sel_alarm = (bus_addr == ADDR_W'(OFS_ALARM));
        start_we  = bus_we && sel_start;
        alarm_we  = bus_we && sel_alarm;
        ctrl_we   = bus_we && sel_ctrl;
        ack_w     = bus_we && sel_ack && bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            alarm_q <= '0;
            ctrl_q  <= '0;
        end else begin
            if (start_we) begin
                start_q <= bus_wdata[CNT_W-1:0];
            end
            if (alarm_we) begin
                alarm_q <= bus_wdata[CNT_W-1:0];
            end
            if (ctrl_we) begin
                ctrl_q.run    <= bus_wdata[7];
                ctrl_q.reload <= bus_wdata[6];
                ctrl_q.rate   <= rate_e'(bus_wdata[3:2]);
                ctrl_q.mode   <= irq_mode_e'(bus_wdata[0]);
            end
        end
    end

    at_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .rate (ctrl_q.rate),
        .tick (tick)
    );

    at_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .start_we  (start_we),
        .start_din (bus_wdata[CNT_W-1:0]),
        .start_q   (start_q),
        .reload    (ctrl_q.reload),
        .cnt       (cnt),
        .cnt_nxt   (cnt_nxt),
        .step      (step)
    );

    at_irq_unit #(.CNT_W(CNT_W)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .cnt_nxt (cnt_nxt),
        .alarm   (alarm_q),
        .mode    (ctrl_q.mode),
        .ack     (ack_w),
        .hit     (hit),
        .status  (status),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_start) begin
            bus_rdata = DATA_W'(start_q);
        end else if (sel_count) begin
            bus_rdata = DATA_W'(cnt);
        end else if (sel_ctrl) begin
            bus_rdata = DATA_W'(ctrl_word(ctrl_q, status));
        end else if (sel_alarm) begin
            bus_rdata = DATA_W'(alarm_q);
        end
    end

    AST_HIT_AT_ALARM: assert property (@(posedge clk) disable iff (rst)
        (hit && !$past(alarm_we)) |-> (cnt == alarm_q)); // R8
    AST_NO_STALL_HIT: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !hit); // R11
    AST_COUNT_READONLY: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel_count && !tick) |=> $stable(cnt)); // R2

endmodule

// File: tb/sim_alarm_timer.sv
module sim_alarm_timer;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;

    string       q_req[$];
    bit          q_irq[$];
    logic [31:0] q_exp[$];

    string       m_req;
    bit          m_irq;
    logic [31:0] m_exp;
    logic [31:0] m_act;

    always #4 clk = ~clk;

    alarm_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic exp_rd(input string r, input logic [7:0] a, input logic [31:0] e);
        bus_addr = a;
        q_req.push_back(r);
        q_irq.push_back(1'b0);
        q_exp.push_back(e);
    endtask

    task automatic exp_irq(input string r, input bit e);
        q_req.push_back(r);
        q_irq.push_back(1'b1);
        q_exp.push_back({31'b0, e});
    endtask

    // Monitor: compares queued expectations 1 ns after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_exp.size() > 0) begin
                m_req = q_req.pop_front();
                m_irq = q_irq.pop_front();
                m_exp = q_exp.pop_front();
                m_act = m_irq ? {31'b0, irq} : bus_rdata;
                n_tests++;
                if (m_act !== m_exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", m_req, m_act, m_exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        // R1 reset state
        exp_rd("R1 start", 8'h20, 32'h0); exp_irq("R1 irq", 1'b0); step(1);
        exp_rd("R1 count", 8'h24, 32'h0); step(1);
        exp_rd("R1 ctrl",  8'h28, 32'h0); step(1);
        exp_rd("R1 ack",   8'h2C, 32'h0); step(1);
        exp_rd("R1 alarm", 8'h30, 32'h0);

        // R2 readback and layout
        wr(8'h30, 32'hDEADBEEF);
        exp_rd("R2 alarm readback", 8'h30, 32'hDEADBEEF);
        wr(8'h28, 32'hFFFF_FFFF);
        exp_rd("R2 ctrl layout", 8'h28, 32'h0000_00CD);
        wr(8'h28, 32'h0);
        wr(8'h24, 32'h1234);
        exp_rd("R2 count write ignored", 8'h24, 32'h0);

        // R3 start write
        wr(8'h20, 32'd100);
        exp_rd("R3 count loaded", 8'h24, 32'd100); step(1);
        exp_rd("R2 start readback", 8'h20, 32'd100);
        // R4 stopped
        step(5);
        exp_rd("R4 stopped count", 8'h24, 32'd100);

        // R5 rate 1
        wr(8'h28, 32'h80);
        exp_rd("R5 div1 k0", 8'h24, 32'd100); step(1);
        exp_rd("R5 div1 k1", 8'h24, 32'd101); step(3);
        exp_rd("R5 div1 k4", 8'h24, 32'd104);
        wr(8'h28, 32'h0);

        // R5 rate 16
        wr(8'h20, 32'd1000);
        wr(8'h28, 32'h84);
        step(15);
        exp_rd("R5 div16 k15", 8'h24, 32'd1000); step(1);
        exp_rd("R5 div16 k16", 8'h24, 32'd1001);
        wr(8'h28, 32'h0);

        // R5 rate 256 via code 3
        wr(8'h20, 32'd50);
        wr(8'h28, 32'h8C);
        step(255);
        exp_rd("R5 div256 k255", 8'h24, 32'd50); step(1);
        exp_rd("R5 div256 k256", 8'h24, 32'd51);
        wr(8'h28, 32'h0);

        // R6 free wrap
        wr(8'h20, 32'hFFFF_FFFE);
        wr(8'h28, 32'h80);
        step(1);
        exp_rd("R6 all ones", 8'h24, 32'hFFFF_FFFF); step(1);
        exp_rd("R6 wrap to zero", 8'h24, 32'h0);
        wr(8'h28, 32'h0);

        // R7 reload wrap
        wr(8'h20, 32'hFFFF_FFFE);
        wr(8'h28, 32'hC0);
        step(2);
        exp_rd("R7 reload value", 8'h24, 32'hFFFF_FFFE); step(1);
        exp_rd("R7 after reload", 8'h24, 32'hFFFF_FFFF);
        wr(8'h28, 32'h0);

        // R8 / R9 pulse mode
        wr(8'h30, 32'h505);
        wr(8'h20, 32'h500);
        wr(8'h28, 32'h80);
        exp_irq("R9 idle", 1'b0);
        step(5);
        exp_irq("R9 pulse", 1'b1);
        exp_rd("R8 count at alarm", 8'h24, 32'h505); step(1);
        exp_irq("R9 pulse ends", 1'b0);
        exp_rd("R8 status set", 8'h28, 32'h180);
        wr(8'h28, 32'h0);
        exp_rd("R8 status sticky", 8'h28, 32'h100);
        wr(8'h2C, 32'h1);
        exp_rd("R8 status cleared", 8'h28, 32'h0);

        // R10 / R12 held mode
        wr(8'h30, 32'h702);
        wr(8'h20, 32'h700);
        wr(8'h28, 32'h81);
        step(2);
        exp_irq("R10 raised", 1'b1); step(4);
        exp_irq("R10 held", 1'b1);
        wr(8'h2C, 32'h0);
        exp_irq("R12 zero ack keeps irq", 1'b1);
        exp_rd("R12 zero ack keeps status", 8'h28, 32'h181);
        wr(8'h2C, 32'h1);
        exp_irq("R10 acked", 1'b0);
        exp_rd("R10 status cleared", 8'h28, 32'h81);
        wr(8'h28, 32'h0);

        // R11 no event without a step
        wr(8'h28, 32'h01);
        wr(8'h30, 32'h900);
        wr(8'h20, 32'h900);
        exp_irq("R11 load onto alarm", 1'b0); step(3);
        exp_irq("R11 stopped at alarm", 1'b0);
        exp_rd("R11 no status", 8'h28, 32'h01);
        wr(8'h28, 32'h89);
        step(100);
        exp_irq("R11 slow rate at alarm", 1'b0);
        exp_rd("R11 count held", 8'h24, 32'h900);
        wr(8'h28, 32'h0);

        step(3);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule